// File: doc/BRIEF.md
# Clock Source Selector with Failover

This block picks the system clock from three candidates: an internal RC clock, an external crystal clock and a PLL output. It also watches the PLL reference (the crystal clock) and the PLL feedback clock for loss of activity. The RC clock is the selected source after reset. If the selected crystal or PLL clock stops, the block moves back to the RC clock on its own. Source changes go through a glitch-free handshake: the old source is gated off on its falling edge, and only after that is confirmed is the new source enabled.

The selected clock drives two independent dividers. One gives the output clock and the other gives the peripheral bus clock. Each divides by 1, 2 or 4. Software reaches the block through a two-entry register interface clocked by the RC clock. Entry 0 holds the source code and both divider codes. Entry 1 shows the live PLL lock input, three sticky error flags that are cleared by writing one, and the source that is actually running.

Top module: `clksel_failover`

## Requirements
- R1: While reset is held and directly after it, entry 0 reads 0 (RC source, both dividers code 0). Entry 1 reads 0x30: lock 0, flags 0, and running-source field 3, meaning none. About 20 RC cycles after reset is released, the running-source field reads 0 (RC).
- R2: Entry 0 bits [1:0] select the source: 0 is RC, 1 is crystal, 2 is PLL. Writing code 3 leaves the selection unchanged and sets the error flag, entry 1 bit 3.
- R3: A source change is glitch-free. At most one source enable is acknowledged at any time. After the handshake, entry 1 bits [5:4] report the new source, and the output clock runs at that source's period.
- R4: Entry 0 bits [3:2] set the output divider: code 0 divides by 1, code 1 by 2, codes 2 and 3 by 4.
- R5: Entry 0 bits [5:4] set the peripheral clock divider with the same coding as R4, independently of the output divider.
- R6: A monitored clock with no edge for 16 RC cycles counts as lost. A lost crystal clock sets sticky flag entry 1 bit 1. A lost PLL feedback clock sets sticky flag entry 1 bit 2.
- R7: Fallback to RC happens on its own in two cases: the crystal is selected and its clock is lost, or the PLL is selected and either its reference or its feedback clock is lost. Entry 0 bits [1:0] then read 0, and the output clock runs at the RC period.
- R8: A write that selects the PLL while the lock input is low is ignored for the source field and sets the error flag, entry 1 bit 3.
- R9: Writing entry 1 with bit 1, 2 or 3 set clears the matching sticky flag, unless its set condition is still present.
- R10: Entry 1 bit 0 follows the PLL lock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC clock; default source and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_clk | input | 1 | External crystal clock, also the PLL reference |
| pll_clk | input | 1 | PLL output clock |
| pll_fb_clk | input | 1 | PLL feedback clock, monitored for loss |
| pll_lock | input | 1 | PLL lock status |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register entry: 0 control, 1 status |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data of the addressed entry |
| clk_out | output | 1 | Divided system clock |
| pclk_out | output | 1 | Divided peripheral bus clock |

## Verification
The assertions check on every RC cycle that at most one source enable is acknowledged. They also check that a lost selected source forces the selection to RC on the next cycle, that loss sets the sticky flags, that an unlocked PLL request and a code-3 request leave the selection unchanged and raise the error flag, and that a write-one clear takes effect. The following can only be shown by the bench's scenarios, because they are measured as periods on the clock outputs: the divider ratios for every pair of divider codes, the clock period after each handshake, and recovery to the RC rate after the crystal or the PLL is stopped.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/clksel_losmon.sv
module clksel_losmon #(
  parameter int LIMIT = 16
) (
  input  logic mon_clk,
  input  logic rc_clk,
  input  logic rst_n,
  output logic lost
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          tog_q;
  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen;

  // Toggle on every monitored edge; a stalled clock freezes it.
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_q};
  end

  assign seen = sync_q[2] ^ sync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    if (seen)                   cnt_d = '0;
    else if (cnt_q != CW'(LIMIT)) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lost = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/clksel_gate.sv
module clksel_gate (
  input  logic clk_src,
  input  logic rc_clk,
  input  logic rst_n,
  input  logic kill,
  input  logic req,
  output logic ack,
  output logic gclk
);
  logic arst_n;
  logic s1_q, s2_q, en_q;
  logic a1_q, a2_q;

  // A dead source cannot clock its own enable low, so loss clears it directly.
  assign arst_n = rst_n & ~kill;

  always_ff @(posedge clk_src or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= req;
      s2_q <= s1_q;
    end
  end

  // Enable changes only while the source is low.
  always_ff @(negedge clk_src or negedge arst_n) begin
    if (!arst_n) en_q <= 1'b0;
    else         en_q <= s2_q;
  end

  assign gclk = clk_src & en_q;

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_q <= 1'b0;
      a2_q <= 1'b0;
    end else begin
      a1_q <= en_q;
      a2_q <= a1_q;
    end
  end

  assign ack = a2_q;
endmodule

// File: rtl/clksel_div.sv
module clksel_div (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       clk_div
);
  logic [1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    case (code)
      2'd0:    clk_div = clk;
      2'd1:    clk_div = cnt_q[0];
      default: clk_div = cnt_q[1];
    endcase
  end
endmodule

// File: rtl/clksel_failover.sv
module clksel_failover
  import clksel_pkg::*;
#(
  parameter int LOS_LIMIT = 16
) (
  input  logic       rc_clk,
  input  logic       rst_n,
  input  logic       xtal_clk,
  input  logic       pll_clk,
  input  logic       pll_fb_clk,
  input  logic       pll_lock,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [5:0] reg_wdata,
  output logic [5:0] reg_rdata,
  output logic       clk_out,
  output logic       pclk_out
);
  logic            rs1_q, rst_rc_n;
  src_e            src_q, src_d, active;
  logic [1:0]      odiv_q, odiv_d, pdiv_q, pdiv_d;
  logic            ref_flag_q, ref_flag_d, fb_flag_q, fb_flag_d, err_q, err_d;
  logic            ref_lost, fb_lost;
  logic            wr_ctrl, wr_stat, sel_ok, fail;
  logic [NSRC-1:0] src_clk, kill, req, ack, gclk;
  logic            sys_clk;

  // Reset: asserted asynchronously, released on the RC clock.
  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q    <= 1'b0;
      rst_rc_n <= 1'b0;
    end else begin
      rs1_q    <= 1'b1;
      rst_rc_n <= rs1_q;
    end
  end

  clksel_losmon #(.LIMIT(LOS_LIMIT)) u_ref_mon (
    .mon_clk(xtal_clk), .rc_clk(rc_clk), .rst_n(rst_rc_n), .lost(ref_lost));
  clksel_losmon #(.LIMIT(LOS_LIMIT)) u_fb_mon (
    .mon_clk(pll_fb_clk), .rc_clk(rc_clk), .rst_n(rst_rc_n), .lost(fb_lost));

  assign src_clk = {pll_clk, xtal_clk, rc_clk};
  assign kill    = {fb_lost, ref_lost, 1'b0};

  for (genvar i = 0; i < NSRC; i++) begin : g_ch
    // Request only once every other source has confirmed it is off.
    assign req[i] = (src_q == src_e'(i)) &&
                    ((ack & ~(NSRC'(1) << i)) == '0);
    clksel_gate u_gate (
      .clk_src(src_clk[i]), .rc_clk(rc_clk), .rst_n(rst_rc_n),
      .kill(kill[i]), .req(req[i]), .ack(ack[i]), .gclk(gclk[i]));
  end

  assign sys_clk = |gclk;

  clksel_div u_out_div (
    .clk(sys_clk), .rst_n(rst_rc_n), .code(odiv_q), .clk_div(clk_out));
  clksel_div u_per_div (
    .clk(sys_clk), .rst_n(rst_rc_n), .code(pdiv_q), .clk_div(pclk_out));

  always_comb begin
    case (ack)
      3'b001:  active = SRC_RC;
      3'b010:  active = SRC_XTAL;
      3'b100:  active = SRC_PLL;
      default: active = SRC_NONE;
    endcase
  end

  // Next-state logic for the register file.
  always_comb begin
    wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    wr_stat = reg_we && (reg_addr == ADDR_STAT);
    sel_ok  = (reg_wdata[1:0] != 2'd3) &&
              !((reg_wdata[1:0] == 2'd2) && !pll_lock);
    fail    = ((src_q == SRC_XTAL) && ref_lost) ||
              ((src_q == SRC_PLL) && (ref_lost || fb_lost));

    src_d  = src_q;
    odiv_d = odiv_q;
    pdiv_d = pdiv_q;
    if (wr_ctrl) begin
      odiv_d = reg_wdata[3:2];
      pdiv_d = reg_wdata[5:4];
      if (sel_ok) src_d = src_e'(reg_wdata[1:0]);
    end
    if (fail) src_d = SRC_RC;

    ref_flag_d = (ref_flag_q & ~(wr_stat & reg_wdata[1])) | ref_lost;
    fb_flag_d  = (fb_flag_q  & ~(wr_stat & reg_wdata[2])) | fb_lost;
    err_d      = (err_q      & ~(wr_stat & reg_wdata[3])) | (wr_ctrl & ~sel_ok);
  end

  always_ff @(posedge rc_clk or negedge rst_rc_n) begin
    if (!rst_rc_n) begin
      src_q      <= SRC_RC;
      odiv_q     <= '0;
      pdiv_q     <= '0;
      ref_flag_q <= 1'b0;
      fb_flag_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      src_q      <= src_d;
      odiv_q     <= odiv_d;
      pdiv_q     <= pdiv_d;
      ref_flag_q <= ref_flag_d;
      fb_flag_q  <= fb_flag_d;
      err_q      <= err_d;
    end
  end

  always_comb begin
    if (reg_addr == ADDR_CTRL)
      reg_rdata = {pdiv_q, odiv_q, src_q};
    else
      reg_rdata = {active, err_q, fb_flag_q, ref_flag_q, pll_lock};
  end
endmodule

// File: rtl/clksel_failover_chk.sv
module clksel_failover_chk (
  input logic       rc_clk,
  input logic       rst_n,
  input logic       pll_lock,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [5:0] reg_wdata,
  input logic [1:0] src_q,
  input logic [2:0] ack,
  input logic       ref_lost,
  input logic       fb_lost,
  input logic       ref_flag_q,
  input logic       fb_flag_q,
  input logic       err_q
);
  assert_one_ack_R3: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_bad_code_R2: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (reg_we && !reg_addr && reg_wdata[1:0] == 2'd3)
      |=> (err_q && (src_q == $past(src_q) || src_q == 2'd0)));

  assert_unlocked_pll_R8: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (reg_we && !reg_addr && reg_wdata[1:0] == 2'd2 && !pll_lock && src_q != 2'd2)
      |=> (src_q != 2'd2 && err_q));

  assert_xtal_fail_R7: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (src_q == 2'd1 && ref_lost) |=> src_q == 2'd0);

  assert_pll_fail_R7: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (src_q == 2'd2 && (fb_lost || ref_lost)) |=> src_q == 2'd0);

  assert_ref_sticky_R6: assert property (@(posedge rc_clk) disable iff (!rst_n)
    ref_lost |=> ref_flag_q);

  assert_fb_sticky_R6: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fb_lost |=> fb_flag_q);

  assert_err_clear_R9: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (reg_we && reg_addr && reg_wdata[3]) |=> !err_q);
endmodule

bind clksel_failover clksel_failover_chk u_chk (
  .rc_clk(rc_clk), .rst_n(rst_n), .pll_lock(pll_lock), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .src_q(src_q), .ack(ack),
  .ref_lost(ref_lost), .fb_lost(fb_lost), .ref_flag_q(ref_flag_q),
  .fb_flag_q(fb_flag_q), .err_q(err_q));

// File: tb/clksel_failover_test.sv
`timescale 1ns/1ps
module clksel_failover_test;
  logic       rc_clk = 1'b0, xtal_clk = 1'b0, pll_clk = 1'b0;
  logic       rst_n = 1'b0, pll_lock = 1'b0;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic       clk_out, pclk_out;
  logic       xtal_run = 1'b1, pll_run = 1'b1;
  int         n_chk = 0, n_fail = 0;

  localparam real RC_T = 20.0, XTAL_T = 60.0, PLL_T = 40.0;

  clksel_failover uut (
    .rc_clk(rc_clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .pll_clk(pll_clk),
    .pll_fb_clk(pll_clk), .pll_lock(pll_lock), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_out(clk_out), .pclk_out(pclk_out));

  always #10 rc_clk = ~rc_clk;
  initial forever begin #30; xtal_clk = xtal_run ? ~xtal_clk : 1'b0; end
  initial forever begin #20; pll_clk  = pll_run  ? ~pll_clk  : 1'b0; end

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_t(input string req, input realtime act, input realtime exp);
    n_chk++;
    if (act < exp - 1.0 || act > exp + 1.0) begin
      n_fail++;
      $display("FAIL %s: actual period %0.1f expected %0.1f", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge rc_clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge rc_clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [5:0] d);
    @(negedge rc_clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_rc(input int n);
    repeat (n) @(posedge rc_clk);
  endtask

  task automatic per_out(output realtime p);
    realtime t0;
    repeat (2) @(posedge clk_out);
    t0 = $realtime;
    @(posedge clk_out);
    p = $realtime - t0;
  endtask

  task automatic per_pclk(output realtime p);
    realtime t0;
    repeat (2) @(posedge pclk_out);
    t0 = $realtime;
    @(posedge pclk_out);
    p = $realtime - t0;
  endtask

  function automatic real ratio(input int code);
    return (code == 0) ? 1.0 : (code == 1) ? 2.0 : 4.0;
  endfunction

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] d;
    realtime    p;

    wait_rc(3);
    rd(1'b0, d); chk("R1 ctrl in reset", d, 6'h00);
    rd(1'b1, d); chk("R1 status in reset", d, 6'h30);
    @(negedge rc_clk); rst_n = 1'b1;
    rd(1'b0, d); chk("R1 ctrl after reset", d, 6'h00);
    wait_rc(20);
    rd(1'b1, d); chk("R1 RC running", d, 6'h00);
    per_out(p); chk_t("R1 RC period", p, RC_T);

    // R4 R5: full sweep of both divider codes on the RC source.
    for (int o = 0; o < 4; o++) begin
      for (int q = 0; q < 4; q++) begin
        wr(1'b0, {q[1:0], o[1:0], 2'd0});
        per_out(p);  chk_t("R4 output divider", p, RC_T * ratio(o));
        per_pclk(p); chk_t("R5 peripheral divider", p, RC_T * ratio(q));
      end
    end

    // R3: move to the crystal.
    wr(1'b0, 6'b10_01_01);
    wait_rc(40);
    rd(1'b1, d); chk("R3 crystal active", d, 6'h10);
    per_out(p);  chk_t("R3 crystal out /2", p, XTAL_T * 2.0);
    per_pclk(p); chk_t("R5 crystal pclk /4", p, XTAL_T * 4.0);
    wr(1'b0, 6'b00_00_01);
    per_out(p);  chk_t("R3 crystal out /1", p, XTAL_T);

    // R2: code 3 ignored, error raised; R9 clears it.
    wr(1'b0, 6'b00_00_11);
    rd(1'b0, d); chk("R2 code 3 ignored", d, 6'h01);
    rd(1'b1, d); chk("R2 error flag", d, 6'h18);
    wr(1'b1, 6'b00_1000);
    rd(1'b1, d); chk("R9 error cleared", d, 6'h10);

    // R8: PLL refused while unlocked.
    wr(1'b0, 6'b00_00_10);
    rd(1'b0, d); chk("R8 PLL refused", d, 6'h01);
    rd(1'b1, d); chk("R8 error flag", d, 6'h18);
    wr(1'b1, 6'b00_1000);

    // R10 and R3: lock, then switch to the PLL.
    @(negedge rc_clk); pll_lock = 1'b1;
    rd(1'b1, d); chk("R10 lock seen", d, 6'h11);
    wr(1'b0, 6'b00_00_10);
    wait_rc(40);
    rd(1'b1, d); chk("R3 PLL active", d, 6'h21);
    per_out(p); chk_t("R3 PLL period", p, PLL_T);

    // R6 R7: PLL stops, fallback to RC.
    @(negedge rc_clk); pll_run = 1'b0;
    wait_rc(60);
    rd(1'b0, d); chk("R7 select back to RC", d, 6'h00);
    rd(1'b1, d); chk("R6 feedback flag", d, 6'h05);
    per_out(p); chk_t("R7 RC after PLL loss", p, RC_T);
    @(negedge rc_clk); pll_run = 1'b1;
    wait_rc(10);
    wr(1'b1, 6'b00_0100);
    rd(1'b1, d); chk("R9 feedback flag cleared", d, 6'h01);

    // R6 R7: crystal stops while selected.
    wr(1'b0, 6'b00_00_01);
    wait_rc(40);
    rd(1'b1, d); chk("R3 crystal again", d, 6'h11);
    @(negedge rc_clk); xtal_run = 1'b0;
    wait_rc(60);
    rd(1'b0, d); chk("R7 crystal fallback", d, 6'h00);
    rd(1'b1, d); chk("R6 reference flag", d, 6'h03);
    per_out(p); chk_t("R7 RC after crystal loss", p, RC_T);
    wr(1'b1, 6'b00_0010);
    rd(1'b1, d); chk("R9 flag held while lost", d, 6'h03);
    @(negedge rc_clk); xtal_run = 1'b1;
    wait_rc(10);
    wr(1'b1, 6'b00_0010);
    rd(1'b1, d); chk("R9 reference flag cleared", d, 6'h01);

    @(negedge rc_clk); pll_lock = 1'b0;
    rd(1'b1, d); chk("R10 lock dropped", d, 6'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule